// File: doc/BRIEF.md
# Multicart address-latched bank mapper

This block sits between an 8-bit console's CPU and video buses and the ROMs of a multi-game cartridge. Any CPU write to the upper 32 KB window reloads its whole configuration, and nearly all of the new configuration comes from the write address rather than the data bus. The latched state holds a PRG page, a PRG mode, a chip-select code, a CHR bank and the nametable mirroring.

PRG reads are turned into a linear address that spans three 512 KB program chips. One chip-select code names a chip that is not fitted, and reads with that code raise an open-bus flag instead of enabling ROM. Video addresses below $2000 are mapped into one 8 KB CHR bank. Four nibble-wide scratch registers are mirrored across $4020-$5FFF. Size parameters mask the bank indices so that smaller builds wrap. A single-chip build ignores the chip-select code.

Top module: `addr_latch_mapper`

## Requirements
- R1: A CPU write with cpu_addr[15]=1 loads the configuration at the next rising clock edge. A write with cpu_addr[15]=0 leaves the configuration unchanged.
- R2: The CHR bank is {cpu_addr[3:0], cpu_wdata[1:0]} of the last configuration write. chr_addr = {bank masked to CHR_BANKS, ppu_addr[12:0]}, and chr_sel = 1 exactly when ppu_addr[13] = 0.
- R3: mirror_h equals cpu_addr[13] of the last configuration write (0 = vertical, 1 = horizontal).
- R4: Chip codes cpu_addr[12:11] = 0, 1 and 3 place PRG reads at prg_addr bits [20:19] = 0, 1 and 2, which are 512 KB steps.
- R5: With chip code 2 and SINGLE_CHIP=0, a CPU read at $8000-$FFFF gives open_bus=1, prg_ce=0 and rd_valid=0.
- R6: When cpu_addr[5]=0 was latched (32 KB mode), prg_addr below the chip field is {page[4:1], cpu_addr[14:0]}, where page = latched cpu_addr[10:6].
- R7: When cpu_addr[5]=1 was latched (16 KB mode), prg_addr below the chip field is {page[4:0], cpu_addr[13:0]}, so $8000-$BFFF and $C000-$FFFF map to the same bytes.
- R8: Four 4-bit registers are indexed by cpu_addr[1:0] anywhere in $4020-$5FFF. A write stores cpu_wdata[3:0]. A read returns {4'b0, nibble} with rd_valid=1.
- R9: After reset the block behaves as after a write of $00 to $8000: 32 KB mode, chip 0, page 0, CHR bank 0, vertical mirroring.
- R10: Bank indices wrap to the PRG_BANKS16 and CHR_BANKS sizes. With SINGLE_CHIP=1 the chip field is always 0 and open_bus is never raised.
- R11: rd_valid is 1 only for reads in $4020-$5FFF and for PRG reads from a fitted chip. Other reads, such as $6000 or $401F, give rd_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU bus address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Qualified CPU write strobe |
| cpu_rd | input | 1 | CPU read cycle |
| cpu_rdata | output | 8 | Scratch register read data |
| rd_valid | output | 1 | Block or ROM supplies read data |
| prg_addr | output | PRG_AW | Linear program ROM address |
| prg_ce | output | 1 | Program ROM enable |
| open_bus | output | 1 | Read hits the missing chip |
| ppu_addr | input | 14 | Video bus address |
| chr_addr | output | CHR_AW | CHR ROM address |
| chr_sel | output | 1 | Video address is in the pattern area |
| mirror_h | output | 1 | 1 = horizontal mirroring |

## Verification
The bench builds two copies side by side on shared inputs. u0 uses the defaults: 32 sixteen-KB banks per chip, 64 CHR banks and three chips, so the open-bus code and the full six-bit CHR bank can be reached. u1 uses 16 PRG banks, 16 CHR banks and SINGLE_CHIP=1. The same writes then show page and CHR bits being masked off, and show the chip code being ignored, open-bus code included.

// File: rtl/addr_latch_mapper.sv
module addr_latch_mapper #(
  parameter int PRG_BANKS16 = 32,
  parameter int CHR_BANKS   = 64,
  parameter bit SINGLE_CHIP = 1'b0,
  parameter int PRG_AW      = $clog2(PRG_BANKS16) + 16,
  parameter int CHR_AW      = $clog2(CHR_BANKS) + 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  output logic [7:0]        cpu_rdata,
  output logic              rd_valid,
  output logic [PRG_AW-1:0] prg_addr,
  output logic              prg_ce,
  output logic              open_bus,
  input  logic [13:0]       ppu_addr,
  output logic [CHR_AW-1:0] chr_addr,
  output logic              chr_sel,
  output logic              mirror_h
);
  localparam int PBW = $clog2(PRG_BANKS16);
  localparam int CBW = $clog2(CHR_BANKS);
  localparam int OFW = PBW + 14;

  logic [4:0] page;
  logic       mode16;
  logic [1:0] chip;
  logic [5:0] chr_bank;
  logic       mir;
  logic [3:0] nib [4];

  wire cfg_wr  = cpu_wr && cpu_addr[15];
  wire scr_hit = (cpu_addr >= 16'h4020) && (cpu_addr <= 16'h5FFF);
  wire prg_rd  = cpu_rd && cpu_addr[15];
  wire unused_ok = &{1'b0, cpu_wdata[7:4]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page <= '0; mode16 <= 1'b0; chip <= '0; chr_bank <= '0; mir <= 1'b0;
    end else if (cfg_wr) begin
      page     <= cpu_addr[10:6];
      mode16   <= cpu_addr[5];
      chip     <= cpu_addr[12:11];
      chr_bank <= {cpu_addr[3:0], cpu_wdata[1:0]};
      mir      <= cpu_addr[13];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) nib[i] <= '0;
    end else if (cpu_wr && scr_hit) begin
      nib[cpu_addr[1:0]] <= cpu_wdata[3:0];
    end
  end

  logic [1:0]     slot;
  logic [OFW-1:0] ofs;
  logic           missing;

  generate
    if (SINGLE_CHIP) begin : g_one
      assign slot    = 2'd0;
      assign missing = 1'b0;
      wire unused_chip = &{1'b0, chip};
    end else begin : g_three
      assign slot    = (chip == 2'd3) ? 2'd2 : {1'b0, chip[0]};
      assign missing = (chip == 2'd2);
    end
  endgenerate

  always_comb begin
    if (mode16) ofs = {page[PBW-1:0], cpu_addr[13:0]};
    else        ofs = {page[PBW-1:1], cpu_addr[14:0]};
  end

  assign prg_addr  = {slot, ofs};
  assign open_bus  = prg_rd && missing;
  assign prg_ce    = prg_rd && !missing;
  assign rd_valid  = (cpu_rd && scr_hit) || prg_ce;
  assign cpu_rdata = (cpu_rd && scr_hit) ? {4'b0, nib[cpu_addr[1:0]]} : 8'h00;
  assign chr_addr  = {chr_bank[CBW-1:0], ppu_addr[12:0]};
  assign chr_sel   = !ppu_addr[13];
  assign mirror_h  = mir;

  // R5
  openbus_noce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_bus |-> (!prg_ce && !rd_valid));
  // R1
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_wr && cpu_addr[15]) |=> $stable(mirror_h));
  // R3
  mirror_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr[15]) |=> (mirror_h == $past(cpu_addr[13])));
  // R8
  nib_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !prg_ce) |-> (cpu_rdata[7:4] == 4'h0));
  // R11
  valid_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> cpu_rd);
endmodule

// File: tb/sim_addr_latch_mapper.sv
`timescale 1ns/1ps
module sim_addr_latch_mapper;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic [7:0] rd0, rd1;
  logic v0, v1, ce0, ce1, ob0, ob1, cs0, cs1, m0, m1;
  logic [20:0] pa0;
  logic [19:0] pa1;
  logic [18:0] ca0;
  logic [16:0] ca1;
  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  addr_latch_mapper u0 (.clk, .rst_n, .cpu_addr, .cpu_wdata, .cpu_wr, .cpu_rd,
    .cpu_rdata(rd0), .rd_valid(v0), .prg_addr(pa0), .prg_ce(ce0), .open_bus(ob0),
    .ppu_addr, .chr_addr(ca0), .chr_sel(cs0), .mirror_h(m0));

  addr_latch_mapper #(.PRG_BANKS16(16), .CHR_BANKS(16), .SINGLE_CHIP(1'b1)) u1 (
    .clk, .rst_n, .cpu_addr, .cpu_wdata, .cpu_wr, .cpu_rd,
    .cpu_rdata(rd1), .rd_valid(v1), .prg_addr(pa1), .prg_ce(ce1), .open_bus(ob1),
    .ppu_addr, .chr_addr(ca1), .chr_sel(cs1), .mirror_h(m1));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  task automatic bus_read(logic [15:0] a);
    @(negedge clk);
    cpu_addr = a; cpu_rd = 1'b1;
    #1;
  endtask

  task automatic t_reset;
    bus_read(16'h8000);
    check("R9 prg 8000", pa0, 32'h0);
    bus_read(16'hC123);
    check("R9 prg C123", pa0, 32'h4123);
    check("R9 mirror", m0, 0);
    ppu_addr = 14'h0ABC; #1;
    check("R9 chr", ca0, 32'h0ABC);
  endtask

  task automatic t_chr;
    bus_write(16'h800A, 8'h03);
    ppu_addr = 14'h0123; #1;
    check("R2 chr bank", ca0, 32'h56123);
    check("R10 chr wrap", ca1, 32'h16123);
    check("R2 chr_sel low", cs0, 1);
    ppu_addr = 14'h2000; #1;
    check("R2 chr_sel high", cs0, 0);
  endtask

  task automatic t_mirror;
    bus_write(16'hA000, 8'h00);
    #1 check("R3 horizontal", m0, 1);
    bus_write(16'h8000, 8'h00);
    #1 check("R3 vertical", m0, 0);
  endtask

  task automatic t_mode32;
    bus_write(16'h8D40, 8'h00);
    bus_read(16'h8000);
    check("R4 R6 chip1 lo", pa0, 32'hD0000);
    check("R10 single lo", pa1, 32'h10000);
    bus_read(16'hFFFF);
    check("R6 hi", pa0, 32'hD7FFF);
    check("R10 single hi", pa1, 32'h17FFF);
    check("R11 ce", ce0, 1);
  endtask

  task automatic t_mode16;
    bus_write(16'h9CE0, 8'h00);
    bus_read(16'h8005);
    check("R4 R7 chip3 lo", pa0, 32'h14C005);
    check("R10 mode16 wrap", pa1, 32'hC005);
    bus_read(16'hC005);
    check("R7 mirror half", pa0, 32'h14C005);
  endtask

  task automatic t_open;
    bus_write(16'h9000, 8'h00);
    bus_read(16'h8000);
    check("R5 open_bus", ob0, 1);
    check("R5 prg_ce", ce0, 0);
    check("R5 rd_valid", v0, 0);
    check("R10 no open bus", ob1, 0);
    check("R10 single ce", ce1, 1);
  endtask

  task automatic t_scratch;
    bus_write(16'h4021, 8'hAB);
    bus_write(16'h4022, 8'h5C);
    bus_read(16'h5FE5);
    check("R8 mirror read", rd0, 32'h0B);
    check("R8 valid", v0, 1);
    bus_read(16'h4022);
    check("R8 read", rd0, 32'h0C);
    bus_read(16'h8000);
    check("R1 low write ignored", ob0, 1);
    check("R1 mirror kept", m0, 0);
  endtask

  task automatic t_invalid;
    bus_read(16'h6000);
    check("R11 6000", v0, 0);
    bus_read(16'h401F);
    check("R11 401F", v0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_chr();
    t_mirror();
    t_mode32();
    t_mode16();
    t_open();
    t_scratch();
    t_invalid();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule